// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps wall-clock time as binary-coded decimal: seconds, minutes, hours, day of week, day of month, month and a two-digit year, plus a century flag. Software reaches it through eight byte-wide registers at consecutive addresses. One address serves both reads and writes. Reads are combinational on the address. Writes take effect at the next rising clock edge.

An external one-pulse-per-second `tick` advances the calendar. Every carry is done in BCD: seconds feed minutes, minutes feed hours, hours feed both the day of week and the day of month, the day of month feeds the month, and the month feeds the year. The day-of-month limit depends on the month and, for February, on whether the year is a multiple of four.

A stop flag in bit 7 of the seconds register freezes the whole calendar. Clearing the flag lets counting go on from the frozen value. Each time field has its own validity check on writes. A rejected value leaves that field as it was.

Top module: `caltime_regs`

Register addresses: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day/century, 5 date, 6 month, 7 year.

## Requirements
- R1: After reset the eight registers read, from address 0 to 7: 0x90, 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00.
- R2: Each `tick` taken while the stop flag is clear adds one second. The carries run in BCD: 59 s gives 00 s and one more minute, 59 min gives 00 min and one more hour, and 23 h gives 00 h and one more day.
- R3: A day carry sets the date to 01 and advances the month once the date has reached the month length. The month length is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February has 29 days when the binary year is divisible by 4 and 28 otherwise. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R4: A day carry advances the day of week (bits 2:0 of address 4) by one, and a value of 7 becomes 1.
- R5: A write to address 1 always stores data bit 7 as the stop flag, whether or not the seconds value is accepted. While the flag is set, ticks change nothing. After the flag is cleared, counting resumes from the held value.
- R6: Reading address 1 returns the stop flag in bit 7 and the BCD seconds in bits 6:0.
- R7: A write value is valid BCD only if both nibbles are 0 to 9. Seconds and minutes take data bits 6:0 and accept 00 to 59. Hours take data bits 5:0 and accept 00 to 23. A rejected value leaves that field unchanged.
- R8: The date takes data bits 5:0 and accepts any valid BCD value except 00. The month takes data bits 4:0 and accepts 01 to 12. The year takes all 8 data bits and accepts 00 to 99. A rejected value leaves that field unchanged.
- R9: A write to address 4 always stores data bits 2:0 as the day of week and data bit 6 as the century flag. A read returns the century flag in bit 6, the day of week in bits 2:0, and zeros elsewhere.
- R10: A write to address 0 stores the data with bits 7 and 5 cleared and then bits 7 and 4 set.
- R11: An accepted write is visible on the next read after the clock edge and changes no other field. In a cycle with both a tick and a write, the written field takes the written value and every other field takes its ticked value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address for both reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |

## Verification
The bench builds the block with `LEAP_EN` = 1 and `RST_STAGES` = 2. With these values February 29 can be reached and tested in years such as 24 and 00. The two-stage reset release makes the first usable cycle predictable. Directed sequences start from 23:59:59 on month-end dates and push a single tick through every carry level: the 28-, 29-, 30- and 31-day month ends and the wrap from year 99 to 00. The random sequences mix ticks with in-range and out-of-range writes to every address, often in the same cycle, to check that each field takes its value independently.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

  localparam int BYTE_W  = 8;
  localparam int REG_CNT = 8;
  localparam int ADDR_W  = $clog2(REG_CNT);

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_SEC   = 3'd1,
    A_MIN   = 3'd2,
    A_HOUR  = 3'd3,
    A_DAYC  = 3'd4,
    A_DATE  = 3'd5,
    A_MONTH = 3'd6,
    A_YEAR  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
  } caltime_t;

  localparam caltime_t CT_RESET = '{
    sec:   7'h00,
    min:   7'h00,
    hour:  6'h00,
    dow:   3'd1,
    date:  6'h01,
    month: 5'h01,
    year:  8'h00
  };

  localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h90;
  localparam logic [BYTE_W-1:0] CTRL_CLR   = 8'hA0;
  localparam logic [BYTE_W-1:0] CTRL_SET   = 8'h90;

  // Both nibbles decimal
  function automatic logic bcd_ok(input logic [7:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  // Add one in BCD (no wrap handling; callers wrap before the limit)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/caltime_wrchk.sv
module caltime_wrchk
  import caltime_pkg::*;
(
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [REG_CNT-1:0]  sel,
  output logic [REG_CNT-1:0]  ld
);

  // Per-field acceptance rule, keyed by register
  function automatic logic field_ok(input reg_sel_e r, input logic [7:0] v);
    logic ok;
    case (r)
      A_SEC, A_MIN: ok = bcd_ok({1'b0, v[6:0]}) && (v[6:0] <= 7'h59);
      A_HOUR:       ok = bcd_ok({2'b0, v[5:0]}) && (v[5:0] <= 6'h23);
      A_DATE:       ok = bcd_ok({2'b0, v[5:0]}) && (v[5:0] != 6'h00);
      A_MONTH:      ok = bcd_ok({3'b0, v[4:0]}) && (v[4:0] >= 5'h01) && (v[4:0] <= 5'h12);
      A_YEAR:       ok = bcd_ok(v);
      default:      ok = 1'b1;
    endcase
    return ok;
  endfunction

  for (genvar i = 0; i < REG_CNT; i++) begin : g_field
    localparam reg_sel_e SEL = reg_sel_e'(i);
    assign sel[i] = wr_en && (addr == SEL);
    assign ld[i]  = sel[i] && field_ok(SEL, wr_data);
  end

endmodule

// File: rtl/caltime_advance.sv
module caltime_advance
  import caltime_pkg::*;
#(
  parameter bit LEAP_EN = 1'b1
) (
  input  caltime_t cur,
  output caltime_t nxt
);

  logic [7:0] inc_sec, inc_min, inc_hour, inc_date, inc_mon, inc_year;
  logic [7:0] dim;
  logic [6:0] ybin;
  logic       leap;

  assign inc_sec  = bcd_inc({1'b0, cur.sec});
  assign inc_min  = bcd_inc({1'b0, cur.min});
  assign inc_hour = bcd_inc({2'b0, cur.hour});
  assign inc_date = bcd_inc({2'b0, cur.date});
  assign inc_mon  = bcd_inc({3'b0, cur.month});
  assign inc_year = bcd_inc(cur.year);

  // Month length in BCD
  always_comb begin
    ybin = 7'(cur.year[7:4]) * 7'd10 + 7'(cur.year[3:0]);
    leap = LEAP_EN && (ybin[1:0] == 2'b00);
    case (cur.month)
      5'h02:                      dim = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: dim = 8'h30;
      default:                    dim = 8'h31;
    endcase
  end

  // BCD carry chain
  always_comb begin
    nxt = cur;
    if (cur.sec != 7'h59) begin
      nxt.sec = inc_sec[6:0];
    end else begin
      nxt.sec = 7'h00;
      if (cur.min != 7'h59) begin
        nxt.min = inc_min[6:0];
      end else begin
        nxt.min = 7'h00;
        if (cur.hour != 6'h23) begin
          nxt.hour = inc_hour[5:0];
        end else begin
          nxt.hour = 6'h00;
          nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
          if ({2'b0, cur.date} < dim) begin
            nxt.date = inc_date[5:0];
          end else begin
            nxt.date = 6'h01;
            if (cur.month != 5'h12) begin
              nxt.month = inc_mon[4:0];
            end else begin
              nxt.month = 5'h01;
              nxt.year  = (cur.year == 8'h99) ? 8'h00 : inc_year;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/caltime_regs.sv
module caltime_regs
  import caltime_pkg::*;
#(
  parameter bit LEAP_EN    = 1'b1,
  parameter int RST_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data
);

  // Reset: asynchronous assert, synchronous release
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  // State
  caltime_t           time_q, time_d, time_adv;
  logic               stop_q, stop_d;
  logic               cent_q, cent_d;
  logic [BYTE_W-1:0]  ctrl_q, ctrl_d;
  logic [REG_CNT-1:0] sel, ld;
  logic               run, time_en, stop_en, cent_en, ctrl_en;

  caltime_wrchk u_wrchk (
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .sel     (sel),
    .ld      (ld)
  );

  caltime_advance #(.LEAP_EN(LEAP_EN)) u_adv (
    .cur (time_q),
    .nxt (time_adv)
  );

  assign run     = tick && !stop_q;
  assign time_en = run || (|ld);
  assign stop_en = sel[A_SEC];
  assign cent_en = sel[A_DAYC];
  assign ctrl_en = sel[A_CTRL];

  // Next state: ticked value, then accepted field writes override
  always_comb begin
    time_d = run ? time_adv : time_q;
    if (ld[A_SEC])   time_d.sec   = wr_data[6:0];
    if (ld[A_MIN])   time_d.min   = wr_data[6:0];
    if (ld[A_HOUR])  time_d.hour  = wr_data[5:0];
    if (ld[A_DAYC])  time_d.dow   = wr_data[2:0];
    if (ld[A_DATE])  time_d.date  = wr_data[5:0];
    if (ld[A_MONTH]) time_d.month = wr_data[4:0];
    if (ld[A_YEAR])  time_d.year  = wr_data;
    stop_d = wr_data[7];
    cent_d = wr_data[6];
    ctrl_d = (wr_data & ~CTRL_CLR) | CTRL_SET;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  time_q <= CT_RESET;
    else if (time_en) time_q <= time_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  stop_q <= 1'b0;
    else if (stop_en) stop_q <= stop_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cent_q <= 1'b0;
    else if (cent_en) cent_q <= cent_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= CTRL_RESET;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // Read mux
  always_comb begin
    case (reg_sel_e'(addr))
      A_CTRL:  rd_data = ctrl_q;
      A_SEC:   rd_data = {stop_q, time_q.sec};
      A_MIN:   rd_data = {1'b0, time_q.min};
      A_HOUR:  rd_data = {2'b0, time_q.hour};
      A_DAYC:  rd_data = {1'b0, cent_q, 3'b000, time_q.dow};
      A_DATE:  rd_data = {2'b0, time_q.date};
      A_MONTH: rd_data = {3'b0, time_q.month};
      A_YEAR:  rd_data = time_q.year;
      default: rd_data = '0;
    endcase
  end

  // Assertions
  AST_SEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bcd_ok({1'b0, time_q.sec}) && (time_q.sec <= 7'h59)); // R7

  AST_MONTH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (time_q.month >= 5'h01) && (time_q.month <= 5'h12)); // R8

  AST_CTRL_FORCED_BITS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]); // R10

  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stop_q && !wr_en) |=> $stable(time_q)); // R5

  AST_TICK_MOVES_SEC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && !stop_q && !wr_en) |=> (time_q.sec != $past(time_q.sec))); // R2

  AST_BAD_MIN_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (addr == 3'd2) && !tick && (wr_data[6:4] > 3'd5)) |=> $stable(time_q.min)); // R7

endmodule

// File: tb/tb_caltime_regs.sv
module tb_caltime_regs;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 200000;
  localparam int RAND_OPS   = 1500;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;

  // Reference model (binary)
  int m_sec, m_min, m_hour, m_dow, m_date, m_mon, m_year;
  int m_stop, m_cent, m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  caltime_regs #(.LEAP_EN(1'b1), .RST_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic int to_bcd(int n);
    return ((n / 10) << 4) | (n % 10);
  endfunction

  function automatic bit digits_ok(int v);
    return ((v & 15) <= 9) && (((v >> 4) & 15) <= 9);
  endfunction

  function automatic int from_bcd(int v);
    return ((v >> 4) & 15) * 10 + (v & 15);
  endfunction

  function automatic int month_len(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_date = 1; m_mon = 1;
    m_year = 0; m_stop = 0; m_cent = 0; m_ctrl = 'h90;
  endtask

  task automatic model_tick();
    if (m_stop != 0) return;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hour++;
    if (m_hour < 24) return;
    m_hour = 0;
    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
    if (m_date >= month_len(m_mon, m_year)) begin
      m_date = 1; m_mon++;
      if (m_mon == 13) begin
        m_mon = 1;
        m_year = (m_year + 1) % 100;
      end
    end else begin
      m_date++;
    end
  endtask

  task automatic model_write(int a, int v);
    int f;
    case (a)
      0: m_ctrl = (v & 'h5F) | 'h90;
      1: begin
        f = v & 'h7F;
        if (digits_ok(f) && from_bcd(f) <= 59) m_sec = from_bcd(f);
        m_stop = (v >> 7) & 1;
      end
      2: begin f = v & 'h7F; if (digits_ok(f) && from_bcd(f) <= 59) m_min = from_bcd(f); end
      3: begin f = v & 'h3F; if (digits_ok(f) && from_bcd(f) <= 23) m_hour = from_bcd(f); end
      4: begin m_dow = v & 7; m_cent = (v >> 6) & 1; end
      5: begin f = v & 'h3F; if (digits_ok(f) && f != 0) m_date = from_bcd(f); end
      6: begin
        f = v & 'h1F;
        if (digits_ok(f) && from_bcd(f) >= 1 && from_bcd(f) <= 12) m_mon = from_bcd(f);
      end
      default: begin if (digits_ok(v & 'hFF)) m_year = from_bcd(v & 'hFF); end
    endcase
  endtask

  function automatic int exp_read(int a);
    case (a)
      0: return m_ctrl;
      1: return (m_stop << 7) | to_bcd(m_sec);
      2: return to_bcd(m_min);
      3: return to_bcd(m_hour);
      4: return (m_cent << 6) | m_dow;
      5: return to_bcd(m_date);
      6: return to_bcd(m_mon);
      default: return to_bcd(m_year);
    endcase
  endfunction

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, got, exp);
    end
  endtask

  // Read every register at a falling edge and compare with the model
  task automatic check_all(string req);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      @(negedge clk);
      check(req, $sformatf("addr%0d", a), int'(rd_data), exp_read(a));
    end
  endtask

  // One clock with optional tick and write; model follows tick, then write
  task automatic step(bit t, bit w, int a, int v);
    @(negedge clk);
    tick = t; wr_en = w; addr = 3'(a); wr_data = 8'(v);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    if (t) model_tick();
    if (w) model_write(a, v);
  endtask

  task automatic set_all(int s, int mi, int h, int dc, int d, int mo, int y);
    step(0, 1, 1, s); step(0, 1, 2, mi); step(0, 1, 3, h); step(0, 1, 4, dc);
    step(0, 1, 5, d); step(0, 1, 6, mo); step(0, 1, 7, y);
  endtask

  function automatic int rand_value(int a);
    if ($urandom % 2 == 0) return int'($urandom % 256);
    case (a)
      1: return to_bcd($urandom % 60) | ((($urandom % 8) == 0) ? 'h80 : 0);
      2: return to_bcd($urandom % 60);
      3: return to_bcd($urandom % 24);
      5: return to_bcd(1 + $urandom % 31);
      6: return to_bcd(1 + $urandom % 12);
      7: return to_bcd($urandom % 100);
      default: return int'($urandom % 256);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check_all("R1");

    // R10: control masking
    step(0, 1, 0, 'hFF); check_all("R10");
    step(0, 1, 0, 'h20); check_all("R10");

    // R11: accepted writes land independently
    set_all('h58, 'h59, 'h23, 'h47, 'h28, 'h02, 'h23);
    check_all("R11");
    step(1, 0, 0, 0); check_all("R2");
    // Feb 28, non-leap year 23 -> Mar 01, day of week 7 -> 1
    step(1, 0, 0, 0); check_all("R3");
    check(  "R4", "dow wrap", int'(m_dow), 1);

    // Leap year: Feb 28 in year 24 -> Feb 29
    set_all('h59, 'h59, 'h23, 'h03, 'h28, 'h02, 'h24);
    step(1, 0, 0, 0); check_all("R3");
    step(0, 1, 1, 'h59); step(0, 1, 2, 'h59); step(0, 1, 3, 'h23);
    step(1, 0, 0, 0); check_all("R3");

    // Year end 99 -> 00
    set_all('h59, 'h59, 'h23, 'h05, 'h31, 'h12, 'h99);
    step(1, 0, 0, 0); check_all("R3");
    // 30-day month
    set_all('h59, 'h59, 'h23, 'h02, 'h30, 'h04, 'h10);
    step(1, 0, 0, 0); check_all("R4");

    // R7: rejected seconds/minutes/hours; R5: stop stored regardless
    step(0, 1, 1, 'hE0); check_all("R5");
    step(0, 1, 2, 'h5A); check_all("R7");
    step(0, 1, 3, 'h24); check_all("R7");
    step(0, 1, 3, 'hC0); check_all("R7");

    // R5/R6: stopped, ticks ignored
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    addr = 3'd1; @(negedge clk);
    check("R6", "sec read with stop", int'(rd_data), 'h80 | to_bcd(m_sec));
    check_all("R5");
    step(0, 1, 1, 'h15); step(1, 0, 0, 0); check_all("R5");

    // R8: rejected date, month and year values
    step(0, 1, 5, 'h00); step(0, 1, 5, 'h3F); check_all("R8");
    step(0, 1, 6, 'h13); step(0, 1, 6, 'h00); step(0, 1, 6, 'h0A); check_all("R8");
    step(0, 1, 7, 'h9A); step(0, 1, 7, 'hA0); check_all("R8");
    step(0, 1, 5, 'hF9); check_all("R8");

    // R9: day/century keeps only its fields
    step(0, 1, 4, 'hBD); check_all("R9");
    step(0, 1, 4, 'h7A); check_all("R9");

    // Random mix of ticks and writes
    for (int i = 0; i < RAND_OPS; i++) begin
      int a, v;
      bit t, w;
      a = int'($urandom % 8);
      v = rand_value(a);
      t = ($urandom % 4) != 0;
      w = ($urandom % 3) == 0;
      step(t, w, a, v);
      check_all(w ? "R11" : "R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule